// File: doc/BRIEF.md
# Dot Stream Port Splitter with Polarity Control

The block sits at the end of a display pipeline. Each dot-clock cycle it receives one 4-bit color code, a display-period flag that is high for dots inside the visible part of a line, a display-enable input, and raw horizontal and vertical sync levels. It drives two output ports, A and B. Each port has a color bus and a display-period strobe.

In straight mode, port A carries every dot and port B stays at its inactive level. In split mode, dots are numbered from zero at the start of each line. Even dots go to port A and odd dots go to port B. The two dots of a pair appear together and are held for two dot clocks, so each port runs at half the dot rate.

The display-enable input can blank any dot. The active level of that input, of both sync inputs, of the color outputs and of the period outputs is each selected by a configuration bit. Mode and polarity settings are captured only at a line start, so a single line is never formatted under mixed settings.

Top module: `dot_port_splitter`

## Requirements
- R1: A synchronous active-high reset drives every output to 0 after the next clock edge. It selects straight mode and active-high levels for all signals until the next line start.
- R2: In straight mode, the dot sampled at a clock edge appears on port A after that same edge. Port B's color and period outputs show their inactive level.
- R3: A line start is a cycle where `per_i` is 1 and was 0 in the previous cycle. Dot parity is 0 (even) at a line start and alternates every clock after that, including during blanking.
- R4: In split mode, an even dot is captured and all outputs keep their values across its edge. At the following odd dot's edge, port A shows the captured even dot and port B shows the odd dot.
- R5: While display-enable is at its inactive level, the color and period of that dot are replaced by their inactive levels on the port that carries the dot.
- R6: `cfg_col_low_i`=1 makes color outputs active-low: each bit is inverted, so the inactive color is all ones. `cfg_per_low_i`=1 does the same for both period outputs, whose inactive level is then 1.
- R7: `cfg_de_low_i`=1 makes `de_i`=0 the enabling level. With `cfg_de_low_i`=0, `de_i`=1 enables.
- R8: `hs_o` and `vs_o` are the sync inputs, registered and normalised to active-high. An input is inverted when its polarity bit (`cfg_hs_low_i`, `cfg_vs_low_i`) is 1.
- R9: Mode and polarity inputs take effect only at a line start. Changes made in any other cycle leave the outputs formatted under the earlier settings until the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_split_i | input | 1 | 1 = split even/odd mode, 0 = straight mode |
| cfg_de_low_i | input | 1 | Display-enable input is active low |
| cfg_hs_low_i | input | 1 | Horizontal sync input is active low |
| cfg_vs_low_i | input | 1 | Vertical sync input is active low |
| cfg_col_low_i | input | 1 | Color outputs are active low |
| cfg_per_low_i | input | 1 | Period outputs are active low |
| pix_i | input | COL_W | Color code of the current dot |
| per_i | input | 1 | Display-period flag of the current dot, active high |
| de_i | input | 1 | Display-enable input |
| hs_i | input | 1 | Raw horizontal sync |
| vs_i | input | 1 | Raw vertical sync |
| a_col_o | output | COL_W | Port A color |
| a_per_o | output | 1 | Port A display-period strobe |
| b_col_o | output | COL_W | Port B color |
| b_per_o | output | 1 | Port B display-period strobe |
| hs_o | output | 1 | Normalised horizontal sync |
| vs_o | output | 1 | Normalised vertical sync |

## Verification
The stimulus requests split mode and then straight mode in the middle of a line. A design that applied settings at once would switch format mid-line, and the held pair would change on an even edge. Parity is followed through blanking and reset at the next line start. A counter that froze or failed to clear would put dots on the wrong port.

Blanking is applied to a single odd dot, which must blank only port B while port A still shows its even partner. After polarity inversion, the inactive color must read as all ones, not zero. A reset that follows inverted settings must return every output to 0.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef struct packed {
    logic split;
    logic de_low;
    logic hs_low;
    logic vs_low;
    logic col_low;
    logic per_low;
  } dps_cfg_t;

  localparam dps_cfg_t DPS_CFG_RESET = '0;
endpackage

// File: rtl/dps_line_ctrl.sv
module dps_line_ctrl
  import dps_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     per_i,
  input  dps_cfg_t cfg_in,
  output dps_cfg_t cfg_cur,
  output dps_cfg_t cfg_q,
  output logic     odd_cur,
  output logic     line_start
);
  logic per_prev;
  logic odd_q;

  assign line_start = per_i & ~per_prev;
  assign cfg_cur    = line_start ? cfg_in : cfg_q;
  assign odd_cur    = line_start ? 1'b0 : ~odd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_prev <= 1'b0;
      odd_q    <= 1'b1;
      cfg_q    <= DPS_CFG_RESET;
    end else begin
      per_prev <= per_i;
      odd_q    <= odd_cur;
      cfg_q    <= cfg_cur;
    end
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(per_i && !per_prev) |=> (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/dps_dot_gate.sv
module dps_dot_gate #(
  parameter int COL_W = 4
) (
  input  logic [COL_W-1:0] pix_i,
  input  logic             per_i,
  input  logic             de_i,
  input  logic             de_low,
  output logic             en_o,
  output logic [COL_W-1:0] col_o,
  output logic             per_o
);
  assign en_o  = de_i ^ de_low;
  assign col_o = en_o ? pix_i : '0;
  assign per_o = en_o & per_i;
endmodule

// File: rtl/dps_port_reg.sv
module dps_port_reg #(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [COL_W-1:0] col_nxt,
  input  logic             per_nxt,
  input  logic             col_low,
  input  logic             per_low,
  output logic [COL_W-1:0] col_o,
  output logic             per_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      col_o <= '0;
      per_o <= 1'b0;
    end else if (load) begin
      col_o <= col_nxt ^ {COL_W{col_low}};
      per_o <= per_nxt ^ per_low;
    end
  end
endmodule

// File: rtl/dot_port_splitter.sv
module dot_port_splitter
  import dps_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_split_i,
  input  logic             cfg_de_low_i,
  input  logic             cfg_hs_low_i,
  input  logic             cfg_vs_low_i,
  input  logic             cfg_col_low_i,
  input  logic             cfg_per_low_i,
  input  logic [COL_W-1:0] pix_i,
  input  logic             per_i,
  input  logic             de_i,
  input  logic             hs_i,
  input  logic             vs_i,
  output logic [COL_W-1:0] a_col_o,
  output logic             a_per_o,
  output logic [COL_W-1:0] b_col_o,
  output logic             b_per_o,
  output logic             hs_o,
  output logic             vs_o
);
  localparam int NPORT = 2;

  dps_cfg_t cfg_in, cfg_cur, cfg_q;
  logic odd_cur, line_start;
  logic en;
  logic [COL_W-1:0] g_col;
  logic g_per;
  logic [COL_W-1:0] hold_col;
  logic hold_per;
  logic load;
  logic [COL_W-1:0] nxt_col [NPORT];
  logic nxt_per [NPORT];
  logic [COL_W-1:0] out_col [NPORT];
  logic out_per [NPORT];

  assign cfg_in = '{split: cfg_split_i, de_low: cfg_de_low_i, hs_low: cfg_hs_low_i,
                    vs_low: cfg_vs_low_i, col_low: cfg_col_low_i, per_low: cfg_per_low_i};

  dps_line_ctrl u_line (
    .clk(clk), .rst(rst), .per_i(per_i), .cfg_in(cfg_in),
    .cfg_cur(cfg_cur), .cfg_q(cfg_q), .odd_cur(odd_cur), .line_start(line_start)
  );

  dps_dot_gate #(.COL_W(COL_W)) u_gate (
    .pix_i(pix_i), .per_i(per_i), .de_i(de_i), .de_low(cfg_cur.de_low),
    .en_o(en), .col_o(g_col), .per_o(g_per)
  );

  always_comb begin
    load       = 1'b1;
    nxt_col[0] = g_col;
    nxt_per[0] = g_per;
    nxt_col[1] = '0;
    nxt_per[1] = 1'b0;
    if (cfg_cur.split) begin
      if (!odd_cur) begin
        load = 1'b0;
      end else begin
        nxt_col[0] = hold_col;
        nxt_per[0] = hold_per;
        nxt_col[1] = g_col;
        nxt_per[1] = g_per;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_col <= '0;
      hold_per <= 1'b0;
      hs_o     <= 1'b0;
      vs_o     <= 1'b0;
    end else begin
      if (cfg_cur.split && !odd_cur) begin
        hold_col <= g_col;
        hold_per <= g_per;
      end
      hs_o <= hs_i ^ cfg_cur.hs_low;
      vs_o <= vs_i ^ cfg_cur.vs_low;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dps_port_reg #(.COL_W(COL_W)) u_port (
      .clk(clk), .rst(rst), .load(load),
      .col_nxt(nxt_col[p]), .per_nxt(nxt_per[p]),
      .col_low(cfg_cur.col_low), .per_low(cfg_cur.per_low),
      .col_o(out_col[p]), .per_o(out_per[p])
    );
  end

  assign a_col_o = out_col[0];
  assign a_per_o = out_per[0];
  assign b_col_o = out_col[1];
  assign b_per_o = out_per[1];

  // R1
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (a_col_o == '0 && !a_per_o && b_col_o == '0 && !b_per_o && !hs_o && !vs_o));

  // R2
  straight_b_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_cur.split |=> (b_col_o == {COL_W{cfg_q.col_low}} && b_per_o == cfg_q.per_low));

  // R4
  even_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_cur.split && !odd_cur) |=> ($stable(a_col_o) && $stable(b_col_o)
                                     && $stable(a_per_o) && $stable(b_per_o)));

  // R5
  blank_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_cur.split && !en) |=> (a_col_o == {COL_W{cfg_q.col_low}} && a_per_o == cfg_q.per_low));

  // R8
  hsync_norm_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hs_o == ($past(hs_i) ^ cfg_q.hs_low)));
endmodule

// File: tb/test_dot_port_splitter.sv
module test_dot_port_splitter;
  localparam int COL_W = 4;
  localparam int NVEC  = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_split = 0, cfg_de_low = 0, cfg_hs_low = 0, cfg_vs_low = 0;
  logic cfg_col_low = 0, cfg_per_low = 0;
  logic [COL_W-1:0] pix = '0;
  logic per = 0, de = 1, hs = 0, vs = 0;
  logic [COL_W-1:0] a_col, b_col;
  logic a_per, b_per, hs_o, vs_o;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dot_port_splitter #(.COL_W(COL_W)) i_dot_port_splitter (
    .clk(clk), .rst(rst),
    .cfg_split_i(cfg_split), .cfg_de_low_i(cfg_de_low), .cfg_hs_low_i(cfg_hs_low),
    .cfg_vs_low_i(cfg_vs_low), .cfg_col_low_i(cfg_col_low), .cfg_per_low_i(cfg_per_low),
    .pix_i(pix), .per_i(per), .de_i(de), .hs_i(hs), .vs_i(vs),
    .a_col_o(a_col), .a_per_o(a_per), .b_col_o(b_col), .b_per_o(b_per),
    .hs_o(hs_o), .vs_o(vs_o)
  );

  // {split, de, per, pix} -> {a_col, a_per, b_col, b_per}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0,1'b1,1'b0,4'd0,  4'd0,1'b0,4'd0,1'b0},   // blank, straight
    {1'b0,1'b1,1'b1,4'd3,  4'd3,1'b1,4'd0,1'b0},   // R2 line start
    {1'b0,1'b1,1'b1,4'd5,  4'd5,1'b1,4'd0,1'b0},   // R2
    {1'b0,1'b0,1'b1,4'd7,  4'd0,1'b0,4'd0,1'b0},   // R5 blanked
    {1'b0,1'b1,1'b1,4'd9,  4'd9,1'b1,4'd0,1'b0},   // R2
    {1'b1,1'b1,1'b0,4'd0,  4'd0,1'b0,4'd0,1'b0},   // R9 split asked, no line start
    {1'b1,1'b1,1'b1,4'd2,  4'd0,1'b0,4'd0,1'b0},   // R3 line start, even held
    {1'b1,1'b1,1'b1,4'd4,  4'd2,1'b1,4'd4,1'b1},   // R4 pair
    {1'b1,1'b1,1'b1,4'd6,  4'd2,1'b1,4'd4,1'b1},   // R4 hold
    {1'b1,1'b0,1'b1,4'd8,  4'd6,1'b1,4'd0,1'b0},   // R5 odd blanked
    {1'b1,1'b1,1'b1,4'd10, 4'd6,1'b1,4'd0,1'b0},   // R4 hold
    {1'b1,1'b1,1'b1,4'd11, 4'd10,1'b1,4'd11,1'b1}, // R4 pair
    {1'b0,1'b1,1'b1,4'd12, 4'd10,1'b1,4'd11,1'b1}, // R9 straight asked mid-line
    {1'b0,1'b1,1'b1,4'd13, 4'd12,1'b1,4'd13,1'b1}, // R9 still split
    {1'b0,1'b1,1'b0,4'd0,  4'd12,1'b1,4'd13,1'b1}, // R3 parity runs in blanking
    {1'b0,1'b1,1'b0,4'd0,  4'd0,1'b0,4'd0,1'b0},   // R3 odd in blanking
    {1'b0,1'b1,1'b1,4'd14, 4'd14,1'b1,4'd0,1'b0}   // R9 line start, straight
  };

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] outs();
    return {a_col, a_per, b_col, b_per, hs_o, vs_o};
  endfunction

  initial begin
    #(200000 * 8);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", outs(), 12'h000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      {cfg_split, de, per, pix} = VEC[i][16:10];
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R5/R9 vector %0d", i), outs(), {VEC[i][9:0], 2'b00});
    end

    // R6 R7 R8 R9: all polarities inverted, taken at a line start
    cfg_split = 0; cfg_de_low = 1; cfg_col_low = 1; cfg_per_low = 1;
    cfg_hs_low = 1; cfg_vs_low = 1;
    per = 0; de = 1; pix = 0; hs = 0; vs = 0;
    @(negedge clk);
    chk("R9 polarity not yet applied", outs(), 12'h000);
    per = 1; de = 0; pix = 4'd5; hs = 0; vs = 1;
    @(negedge clk);
    chk("R6 R7 R8 inverted levels", outs(), {4'hA, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0});

    // R9 color polarity change mid-line ignored; R5 R7 de high is inactive
    cfg_col_low = 0;
    de = 1; pix = 4'd6; hs = 1; vs = 1;
    @(negedge clk);
    chk("R5 R7 R9 blank, old polarity", outs(), {4'hF, 1'b1, 4'hF, 1'b1, 1'b0, 1'b0});

    // R1 reset after inverted settings
    rst = 1;
    @(negedge clk);
    chk("R1 reset after inversion", outs(), 12'h000);
    rst = 0;
    cfg_de_low = 0; cfg_per_low = 0; cfg_hs_low = 0; cfg_vs_low = 0;
    per = 1; de = 1; pix = 4'd7; hs = 0; vs = 0;
    @(negedge clk);
    chk("R1 R2 straight after reset", outs(), {4'd7, 1'b1, 4'd0, 1'b0, 2'b00});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule